// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block turns the fill levels of a serial controller's two 64-byte FIFOs, together with a transfer-finished pulse from the shift engine, into sticky interrupt status and one interrupt line. The receive side raises a request once its FIFO is three quarters full. The transmit side raises a request once its FIFO has drained to a quarter or less. A finished transfer raises a third request. Software arms each request through an enable register and acknowledges it by writing ones into the status register. The same register map also holds a level register that shows both FIFO occupancy counts.

The FIFO storage and the shift engine sit outside the block. The block sees only their occupancy counts and the completion pulse. Registers are written through a single-cycle write strobe with a 2-bit address. Reads are combinational on the same address.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is asserted, and at the first cycle after it is released, the enable register, the status register and the `irq` output all read zero.
- R2: A write to address 0 stores only bits 4 (receive), 12 (transmit) and 16 (completion) of the write data into the enable register. Reading address 0 returns those three bits at the same positions, and every other bit reads zero.
- R3: Status bit 4 becomes 1 at the clock edge that samples `rx_level` at 48 or more. It stays 1 after the level falls, until it is cleared. A level of 47 does not set it.
- R4: Status bit 12 becomes 1 at the clock edge that samples `tx_level` at 16 or less. It stays 1 until it is cleared. A level of 17 does not set it.
- R5: Status bit 16 becomes 1 at the clock edge that samples `xfer_done` high. It stays 1 after the pulse ends, until it is cleared.
- R6: A write to address 1 clears each status bit whose data bit is 1 and leaves every other status bit unchanged. Writing all ones clears every pending bit. Status bits other than 4, 12 and 16 always read zero.
- R7: When a level condition still holds while its status bit is cleared, the bit reads 0 after the clearing edge and reads 1 again one clock later.
- R8: An `xfer_done` pulse in the same cycle as a write that clears bit 16 leaves bit 16 set.
- R9: `irq` is a register. It goes to 1 one clock edge after any status bit and its matching enable bit are both 1, and it stays 0 while no such pair exists.
- R10: After zero is written to the enable register, `irq` is 0 from the second clock edge onward, whatever the status holds.
- R11: Reading address 2 returns the receive count in bits 6:0 and the transmit count in bits 22:16, with every other bit zero. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register select: 0 enable, 1 status, 2 levels, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| rx_level | input | 7 | Receive FIFO occupancy, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| xfer_done | input | 1 | Single-cycle pulse when a transfer finishes |
| irq | output | 1 | Registered interrupt request |

## Verification
Each status bit is read back in the cycle right after the edge that should change it. A set or clear applied out of order therefore appears on `reg_rdata` within one clock. A swapped bit position, or a threshold one count off, shows up at once at the 47/48 and 16/17 boundaries. A wrong enable mask, or a wrong number of stages in the `irq` path, shows up on the `irq` pin as early or late by exactly one edge. Both edges of `irq` are sampled. The relevel sequence checks in the cycle after a clear, which catches a design where the level input wins over the write. The write-collision case catches a design that lets the clear win over the completion pulse.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int REG_W = 32;
  localparam int NSRC  = 3;

  // source indices inside the packed per-source vectors
  localparam int SRC_RX   = 0;
  localparam int SRC_TX   = 1;
  localparam int SRC_DONE = 2;

  // register bit each source occupies (shared by enable and status)
  localparam int SRC_POS [NSRC] = '{4, 12, 16};
  // sources that arrive as pulses rather than as levels
  localparam logic [NSRC-1:0] SRC_IS_PULSE = 3'b100;

  localparam int TXCNT_LSB = 16;

  typedef enum logic [1:0] {
    ADDR_EN   = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_LVL  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  function automatic logic reached_high(int unsigned cnt, int unsigned thr);
    return cnt >= thr;
  endfunction

  function automatic logic reached_low(int unsigned cnt, int unsigned thr);
    return cnt <= thr;
  endfunction

  function automatic logic [REG_W-1:0] spread_bits(logic [NSRC-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[SRC_POS[i]] = v[i];
    return r;
  endfunction

  function automatic logic [NSRC-1:0] gather_bits(logic [REG_W-1:0] w);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = w[SRC_POS[i]];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_levels(logic [15:0] rx, logic [15:0] tx);
    logic [REG_W-1:0] r;
    r = '0;
    r[15:0] = rx;
    r[TXCNT_LSB +: 16] = tx;
    return r;
  endfunction

endpackage

// File: rtl/fifo_irq_level.sv
module fifo_irq_level
  import fifo_irq_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int RX_THR = 48,
  parameter int TX_THR = 16
) (
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  output logic             rx_hit,
  output logic             tx_hit
);

  always_comb begin
    rx_hit = reached_high(32'(rx_level), 32'(RX_THR));
    tx_hit = reached_low(32'(tx_level), 32'(TX_THR));
  end

endmodule

// File: rtl/fifo_irq_enable.sv
module fifo_irq_enable
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [NSRC-1:0]  en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= gather_bits(wdata);
  end

endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_vec,
  input  logic             wr_clr,
  input  logic [REG_W-1:0] wdata,
  output logic [NSRC-1:0]  stat_q
);

  logic [NSRC-1:0] clr_vec;

  always_comb clr_vec = gather_bits(wdata) & {NSRC{wr_clr}};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (SRC_IS_PULSE[g]) begin : g_pulse
      // a pulse cannot be repeated, so it wins over a clear
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[g] <= 1'b0;
        else        stat_q[g] <= set_vec[g] | (stat_q[g] & ~clr_vec[g]);
      end
    end else begin : g_level
      // a level persists, so the clear wins and the level re-sets next cycle
      always_ff @(posedge clk) begin
        if (!rst_n)          stat_q[g] <= 1'b0;
        else if (clr_vec[g]) stat_q[g] <= 1'b0;
        else                 stat_q[g] <= stat_q[g] | set_vec[g];
      end
    end
  end

  p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[SRC_RX] && !clr_vec[SRC_RX]) |=> stat_q[SRC_RX]);

  p_tx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[SRC_TX] && !clr_vec[SRC_TX]) |=> stat_q[SRC_TX]);

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[SRC_DONE] && !clr_vec[SRC_DONE]) |=> stat_q[SRC_DONE]);

  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[SRC_DONE] |=> stat_q[SRC_DONE]);

  p_clear_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vec[SRC_RX] |=> !stat_q[SRC_RX]);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[SRC_TX] && !set_vec[SRC_TX]) |=> !stat_q[SRC_TX]);

endmodule

// File: rtl/fifo_irq_line.sv
module fifo_irq_line
  import fifo_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat,
  input  logic [NSRC-1:0] en,
  output logic            irq_q
);

  logic armed;

  always_comb armed = |(stat & en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= armed;
  end

  p_irq_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(|(stat & en))));

  p_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq_q);

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int RX_NUM     = 3,
  parameter int RX_DEN     = 4,
  parameter int TX_NUM     = 1,
  parameter int TX_DEN     = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             xfer_done,
  output logic             irq
);

  localparam int RX_THR = FIFO_DEPTH * RX_NUM / RX_DEN;
  localparam int TX_THR = FIFO_DEPTH * TX_NUM / TX_DEN;

  logic            rx_hit, tx_hit;
  logic [NSRC-1:0] set_vec, en_q, stat_q;
  logic            wr_en_reg, wr_stat_reg;

  always_comb begin
    wr_en_reg   = reg_wr && (reg_addr == ADDR_EN);
    wr_stat_reg = reg_wr && (reg_addr == ADDR_STAT);
    set_vec     = '0;
    set_vec[SRC_RX]   = rx_hit;
    set_vec[SRC_TX]   = tx_hit;
    set_vec[SRC_DONE] = xfer_done;
  end

  fifo_irq_level #(.CNT_W(CNT_W), .RX_THR(RX_THR), .TX_THR(TX_THR)) u_level (
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rx_hit   (rx_hit),
    .tx_hit   (tx_hit)
  );

  fifo_irq_enable u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en_reg),
    .wdata (reg_wdata),
    .en_q  (en_q)
  );

  fifo_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .wr_clr  (wr_stat_reg),
    .wdata   (reg_wdata),
    .stat_q  (stat_q)
  );

  fifo_irq_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat_q),
    .en    (en_q),
    .irq_q (irq)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_EN:   reg_rdata = spread_bits(en_q);
      ADDR_STAT: reg_rdata = spread_bits(stat_q);
      ADDR_LVL:  reg_rdata = pack_levels(16'(rx_level), 16'(tx_level));
      default:   reg_rdata = '0;
    endcase
  end

  // R1: nothing pending right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && en_q == '0 && !irq));

endmodule

// File: tb/fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_test;

  typedef struct {
    bit          is_irq;
    logic [1:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  rx_level = 7'd0;
  logic [6:0]  tx_level = 7'd32;
  logic        xfer_done = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  item_t sb[$];

  localparam logic [31:0] B_RX = 32'h0000_0010;
  localparam logic [31:0] B_TX = 32'h0000_1000;
  localparam logic [31:0] B_DN = 32'h0001_0000;

  always #2 clk = ~clk;

  fifo_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .xfer_done(xfer_done), .irq(irq)
  );

  function automatic logic [31:0] lvl_word(int rx, int tx);
    return (32'(tx) << 16) | 32'(rx);
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb.size() > 0);
      it = sb.pop_front();
      act = it.is_irq ? {31'd0, irq} : reg_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_reg(logic [1:0] a, logic [31:0] e, string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic expect_irq(bit e, string tag);
    item_t it;
    #1;
    it.is_irq = 1'b1; it.addr = 2'd0; it.exp = {31'd0, e}; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic write_reg(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    tick();
    // R1: reset state
    expect_reg(2'd0, 32'h0, "R1 enable in reset");
    expect_reg(2'd1, 32'h0, "R1 status in reset");
    expect_irq(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    tick();
    expect_reg(2'd1, 32'h0, "R1 status after reset");

    // R2: only three enable bits are kept
    write_reg(2'd0, 32'hFFFF_FFFF);
    expect_reg(2'd0, B_RX | B_TX | B_DN, "R2 enable readback");

    // R11: level readout, boundaries not reached (R3/R4)
    rx_level = 7'd47; tx_level = 7'd17;
    tick();
    expect_reg(2'd2, lvl_word(47, 17), "R11 level word");
    expect_reg(2'd1, 32'h0, "R3 R4 no set at 47/17");
    expect_reg(2'd3, 32'h0, "R11 unused address");

    // R3: receive threshold reached
    rx_level = 7'd48;
    tick();
    expect_reg(2'd1, B_RX, "R3 rx bit at 48");
    expect_irq(1'b0, "R9 irq one edge late");
    tick();
    expect_irq(1'b1, "R9 irq raised");
    rx_level = 7'd20;
    tick();
    expect_reg(2'd1, B_RX, "R3 rx bit sticky");

    // R6: clear
    write_reg(2'd1, B_RX);
    expect_reg(2'd1, 32'h0, "R6 rx cleared");
    expect_irq(1'b1, "R9 irq still high one edge");
    tick();
    expect_irq(1'b0, "R9 irq dropped");

    // R7: level still holding when cleared
    rx_level = 7'd50;
    tick();
    expect_reg(2'd1, B_RX, "R7 rx set");
    write_reg(2'd1, B_RX);
    expect_reg(2'd1, 32'h0, "R7 cleared edge");
    tick();
    expect_reg(2'd1, B_RX, "R7 re-set next cycle");

    // R4: transmit threshold
    tx_level = 7'd16;
    tick();
    expect_reg(2'd1, B_RX | B_TX, "R4 tx bit at 16");
    tx_level = 7'd40;
    rx_level = 7'd10;
    tick();
    write_reg(2'd1, 32'h0);
    expect_reg(2'd1, B_RX | B_TX, "R6 zero write no effect");
    write_reg(2'd1, B_TX);
    expect_reg(2'd1, B_RX, "R6 only tx cleared");

    // R5: completion pulse sticky
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    expect_reg(2'd1, B_RX | B_DN, "R5 done set");
    tick();
    expect_reg(2'd1, B_RX | B_DN, "R5 done sticky");

    // R6: all ones clears everything
    write_reg(2'd1, 32'hFFFF_FFFF);
    expect_reg(2'd1, 32'h0, "R6 clear all");

    // R8: pulse collides with clear
    xfer_done = 1'b1;
    write_reg(2'd1, 32'hFFFF_FFFF);
    xfer_done = 1'b0;
    expect_reg(2'd1, B_DN, "R8 done survives clear");
    tick();
    expect_irq(1'b1, "R9 irq from done");

    // R10: mask everything
    write_reg(2'd0, 32'h0);
    expect_reg(2'd0, 32'h0, "R10 enable zero");
    tick();
    expect_irq(1'b0, "R10 irq masked");
    expect_reg(2'd1, B_DN, "R10 status kept");

    // R9: non-matching enable keeps irq low, matching raises it
    write_reg(2'd0, B_RX);
    tick();
    expect_irq(1'b0, "R9 mismatched enable");
    write_reg(2'd0, B_DN);
    expect_reg(2'd0, B_DN, "R2 single enable");
    tick();
    expect_irq(1'b1, "R9 matched enable");

    tick();
    finished = 1'b1;
    finish_run();
  end

endmodule